// File: doc/BRIEF.md
# Prioritised External Interrupt Notifier

This block gathers level requests from a set of external interrupt sources and tells each of several target contexts whether it has work waiting. Each source has a pending bit and a claimed bit. A source counts toward a target only when it is pending, not claimed, and enabled for that target. The target's request line rises when at least one such source has a priority strictly above the target's threshold. Each target is set to machine level or supervisor level, and its request is steered to the matching output.

A handler takes a source with a claim strobe. While the strobe is low, `claim_id` shows the winning source for `claim_tgt`: the highest priority above the threshold, with ties going to the lowest ID, and 0 when no source qualifies. On the clock edge where the strobe is high, that source becomes claimed and its pending bit is cleared. A later complete strobe carrying the same ID clears the claimed bit, and the source can then become pending again. Configuration goes through a single write port. Every width and count is a parameter.

Top module: `intn_notifier`

## Requirements
- R1: After reset, every priority, enable bit, threshold, pending bit and claimed bit is 0, every target is in machine mode, all request outputs are low and `claim_id` is 0.
- R2: A source n with 1 <= n < N_SRC whose level input is high while it is not claimed becomes pending at the next clock edge. After its claimed bit clears, it needs one further edge to become pending again. Source 0 never becomes pending.
- R3: A source counts for a target only when it is pending, not claimed, and its enable bit for that target is set. Each target has its own enable bits.
- R4: A target's request is high exactly when some source that counts for it has a priority strictly greater than the target's threshold. Equal priority does not raise it.
- R5: `claim_id` is the ID of the source that counts for `claim_tgt` and has the highest priority above the threshold, with ties broken toward the lowest ID. It is 0 when no source qualifies.
- R6: On an edge where `claim_req` is high and `claim_id` is nonzero, that source's claimed bit is set and its pending bit is cleared. No other source's bits change. If `claim_id` is 0, nothing changes.
- R7: On an edge where `cmpl_req` is high, the claimed bit of source `cmpl_id` is cleared and every other bit keeps its value. If the same source is also claimed on that edge, the claim takes effect.
- R8: The mode bit for a target is 0 for machine and 1 for supervisor. The target's request drives `mach_irq[t]` when the bit is 0 and `sup_irq[t]` when it is 1. The other output stays low.
- R9: Configuration writes are selected by `cfg_kind`. Kind 0 sets the priority of source `cfg_idx` from the low PRIO_W data bits. Kind 1 sets enable word `cfg_idx` = t*NW + w, where NW = (N_SRC+31)/32; data bit b of that word enables source 32*w + b for target t. Kind 2 sets the threshold of target `cfg_idx`. Kind 3 sets the mode of target `cfg_idx` from data bit 0.
- R10: A source with priority 0 never raises a request and is never returned by `claim_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | N_SRC | Level request per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Selects priority, enable word, threshold or mode |
| cfg_idx | input | IDX_W | Source, enable-word or target index |
| cfg_data | input | 32 | Write data |
| claim_req | input | 1 | Claim strobe for `claim_tgt` |
| claim_tgt | input | TGT_W | Target whose winner is shown and claimed |
| claim_id | output | SRC_W | Winning source for `claim_tgt`, or 0 |
| cmpl_req | input | 1 | Complete strobe |
| cmpl_id | input | SRC_W | Source being completed |
| mach_irq | output | N_TGT | Machine-level request per target |
| sup_irq | output | N_TGT | Supervisor-level request per target |

## Verification
Claim and complete can land on the same edge for different sources. The bench drives both strobes in one cycle: it claims one pending source and completes another that is currently claimed. It then checks that the claimed source stops counting, and that a fresh level pulse on the completed source is accepted as pending again. A complete can also arrive while the source's level is still high. The bench checks that the source does not count on the first edge after the complete and does count on the second. This confirms that the pending logic uses the claimed state from before the edge.

// File: rtl/intn_pkg.sv
package intn_pkg;

   localparam int WORD_BITS = 32;

   typedef enum logic [1:0] {
      CFG_PRIO   = 2'd0,
      CFG_ENABLE = 2'd1,
      CFG_THRESH = 2'd2,
      CFG_MODE   = 2'd3
   } cfg_kind_e;

   function automatic int word_count(input int n_src);
      return (n_src + WORD_BITS - 1) / WORD_BITS;
   endfunction

   function automatic int idx_span(input int n_src, input int n_tgt);
      int en_words;
      en_words = n_tgt * word_count(n_src);
      return (n_src > en_words) ? n_src : en_words;
   endfunction

endpackage

// File: rtl/intn_state.sv
// Per-source pending / claimed bits. Each bit has its own flop, so an update
// to one source can never disturb any other source's state.
module intn_state #(
   parameter int N_SRC = 40,
   parameter int SRC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_level,
   input  logic             claim_en,
   input  logic [SRC_W-1:0] claim_sel,
   input  logic             cmpl_en,
   input  logic [SRC_W-1:0] cmpl_sel,
   output logic [N_SRC-1:0] pend,
   output logic [N_SRC-1:0] clmd
);

   assign pend[0] = 1'b0;
   assign clmd[0] = 1'b0;

   logic unused_lvl0;
   assign unused_lvl0 = src_level[0];

   for (genvar n = 1; n < N_SRC; n++) begin : g_src
      logic hit_claim, hit_cmpl, pend_q, clmd_q;

      assign hit_claim = claim_en && (claim_sel == SRC_W'(n));
      assign hit_cmpl  = cmpl_en  && (cmpl_sel  == SRC_W'(n));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            clmd_q <= 1'b0;
         end else begin
            // pending uses the claimed state from before this edge
            pend_q <= !hit_claim && (pend_q || (src_level[n] && !clmd_q));
            clmd_q <= hit_claim || (clmd_q && !hit_cmpl);
         end
      end

      assign pend[n] = pend_q;
      assign clmd[n] = clmd_q;

      assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !(pend_q && clmd_q));
      assert_claim_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
         hit_claim |=> (clmd_q && !pend_q));
      assert_cmpl_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_cmpl && !hit_claim) |=> !clmd_q);
   end

endmodule

// File: rtl/intn_cfg.sv
module intn_cfg
   import intn_pkg::*;
#(
   parameter int N_SRC  = 40,
   parameter int N_TGT  = 2,
   parameter int PRIO_W = 3,
   parameter int NW     = 2,
   parameter int IDX_W  = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [1:0]                  cfg_kind,
   input  logic [IDX_W-1:0]            cfg_idx,
   input  logic [WORD_BITS-1:0]        cfg_data,
   output logic [N_SRC-1:0][PRIO_W-1:0] prio,
   output logic [N_TGT-1:0][N_SRC-1:0] enab,
   output logic [N_TGT-1:0][PRIO_W-1:0] thresh,
   output logic [N_TGT-1:0]            sup_mode
);

   cfg_kind_e kind;
   assign kind = cfg_kind_e'(cfg_kind);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio     <= '0;
         enab     <= '0;
         thresh   <= '0;
         sup_mode <= '0;
      end else if (cfg_we) begin
         case (kind)
            CFG_PRIO: begin
               for (int n = 0; n < N_SRC; n++)
                  if (cfg_idx == IDX_W'(n)) prio[n] <= cfg_data[PRIO_W-1:0];
            end
            CFG_ENABLE: begin
               // source n sits in enable word n/32 at bit n%32
               for (int t = 0; t < N_TGT; t++)
                  for (int n = 0; n < N_SRC; n++)
                     if (cfg_idx == IDX_W'(t*NW + n/WORD_BITS))
                        enab[t][n] <= cfg_data[n%WORD_BITS];
            end
            CFG_THRESH: begin
               for (int t = 0; t < N_TGT; t++)
                  if (cfg_idx == IDX_W'(t)) thresh[t] <= cfg_data[PRIO_W-1:0];
            end
            default: begin
               for (int t = 0; t < N_TGT; t++)
                  if (cfg_idx == IDX_W'(t)) sup_mode[t] <= cfg_data[0];
            end
         endcase
      end
   end

endmodule

// File: rtl/intn_select.sv
// Picks the highest-priority eligible source above the threshold; strict
// comparison keeps the lowest ID on a tie.
module intn_select #(
   parameter int N_SRC  = 40,
   parameter int PRIO_W = 3,
   parameter int SRC_W  = 6
) (
   input  logic [N_SRC-1:0]             elig,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]            thresh,
   output logic [SRC_W-1:0]             win_id,
   output logic                         req
);

   logic [PRIO_W-1:0] best_p;

   always_comb begin
      best_p = thresh;
      win_id = '0;
      for (int n = 0; n < N_SRC; n++) begin
         if (elig[n] && (prio[n] > best_p)) begin
            best_p = prio[n];
            win_id = SRC_W'(n);
         end
      end
   end

   assign req = (win_id != '0);

endmodule

// File: rtl/intn_notifier.sv
module intn_notifier
   import intn_pkg::*;
#(
   parameter int N_SRC  = 40,
   parameter int N_TGT  = 2,
   parameter int PRIO_W = 3,
   localparam int NW    = word_count(N_SRC),
   localparam int SRC_W = $clog2(N_SRC),
   localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1,
   localparam int IDX_W = $clog2(idx_span(N_SRC, N_TGT))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_level,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_kind,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [31:0]      cfg_data,
   input  logic             claim_req,
   input  logic [TGT_W-1:0] claim_tgt,
   output logic [SRC_W-1:0] claim_id,
   input  logic             cmpl_req,
   input  logic [SRC_W-1:0] cmpl_id,
   output logic [N_TGT-1:0] mach_irq,
   output logic [N_TGT-1:0] sup_irq
);

   if (N_SRC < 2 || N_SRC > 1024) begin : g_bad_nsrc
      $error("N_SRC out of range");
   end
   if (N_TGT < 1 || N_TGT > 32) begin : g_bad_ntgt
      $error("N_TGT out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("PRIO_W out of range");
   end

   logic [N_SRC-1:0]             pend, clmd;
   logic [N_SRC-1:0][PRIO_W-1:0] prio;
   logic [N_TGT-1:0][N_SRC-1:0]  enab;
   logic [N_TGT-1:0][PRIO_W-1:0] thresh;
   logic [N_TGT-1:0]             sup_mode;
   logic [N_TGT-1:0][N_SRC-1:0]  elig;
   logic [N_TGT-1:0][SRC_W-1:0]  win_id;
   logic [N_TGT-1:0]             req;
   logic                         claim_en;

   intn_cfg #(
      .N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W), .NW(NW), .IDX_W(IDX_W)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data), .prio(prio), .enab(enab),
      .thresh(thresh), .sup_mode(sup_mode)
   );

   intn_state #(.N_SRC(N_SRC), .SRC_W(SRC_W)) i_state (
      .clk(clk), .rst_n(rst_n), .src_level(src_level),
      .claim_en(claim_en), .claim_sel(claim_id),
      .cmpl_en(cmpl_req), .cmpl_sel(cmpl_id),
      .pend(pend), .clmd(clmd)
   );

   for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
      assign elig[t] = pend & ~clmd & enab[t];

      intn_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) i_sel (
         .elig(elig[t]), .prio(prio), .thresh(thresh[t]),
         .win_id(win_id[t]), .req(req[t])
      );

      assign mach_irq[t] = req[t] && !sup_mode[t];
      assign sup_irq[t]  = req[t] &&  sup_mode[t];

      assert_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mach_irq[t] || sup_irq[t]) |-> ((pend & ~clmd & enab[t]) != '0));
      assert_claim_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (claim_tgt == TGT_W'(t)) |-> ((claim_id != '0) == (mach_irq[t] || sup_irq[t])));
   end

   always_comb begin
      claim_id = '0;
      for (int t = 0; t < N_TGT; t++)
         if (claim_tgt == TGT_W'(t)) claim_id = win_id[t];
   end

   assign claim_en = claim_req && (claim_id != '0);

   assert_claim_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_id != '0) |-> (pend[claim_id] && !clmd[claim_id] && (prio[claim_id] != '0)));
   assert_claim_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      claim_en |=> clmd[$past(claim_id)]);

endmodule

// File: tb/test_intn_notifier.sv
`timescale 1ns/1ps
module test_intn_notifier;

   localparam int N_SRC = 40;
   localparam int N_TGT = 2;
   localparam int PRIO_W = 3;
   localparam int SRC_W = 6;
   localparam int TGT_W = 1;
   localparam int IDX_W = 6;
   localparam int NW = 2;

   logic clk = 0;
   logic rst_n = 0;
   logic [N_SRC-1:0] src_level = '0;
   logic cfg_we = 0;
   logic [1:0] cfg_kind = '0;
   logic [IDX_W-1:0] cfg_idx = '0;
   logic [31:0] cfg_data = '0;
   logic claim_req = 0;
   logic [TGT_W-1:0] claim_tgt = '0;
   logic [SRC_W-1:0] claim_id;
   logic cmpl_req = 0;
   logic [SRC_W-1:0] cmpl_id = '0;
   logic [N_TGT-1:0] mach_irq, sup_irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   intn_notifier #(.N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W)) i_intn_notifier (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .cfg_we(cfg_we),
      .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .claim_req(claim_req), .claim_tgt(claim_tgt), .claim_id(claim_id),
      .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .mach_irq(mach_irq), .sup_irq(sup_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input int kind, input int idx, input int data);
      @(negedge clk);
      cfg_we = 1; cfg_kind = 2'(kind); cfg_idx = IDX_W'(idx); cfg_data = data;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      src_level[n] = 1;
      @(negedge clk);
      src_level[n] = 0;
   endtask

   task automatic do_claim(input int tgt);
      @(negedge clk);
      claim_tgt = TGT_W'(tgt); claim_req = 1;
      @(negedge clk);
      claim_req = 0;
   endtask

   task automatic do_cmpl(input int id);
      @(negedge clk);
      cmpl_id = SRC_W'(id); cmpl_req = 1;
      @(negedge clk);
      cmpl_req = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 mach_irq", int'(mach_irq), 0);
      check("R1 sup_irq", int'(sup_irq), 0);
      check("R1 claim_id", int'(claim_id), 0);

      // R2 source 0 never pends even with priority and enable set
      cfg_wr(0, 0, 7);
      cfg_wr(1, 0, 32'hFFFF_FFFF);
      src_level[0] = 1;
      repeat (3) @(negedge clk);
      check("R2 src0 irq", int'(mach_irq[0]), 0);
      check("R2 src0 id", int'(claim_id), 0);
      src_level[0] = 0;

      // R4/R10 sweep of priority against threshold on source 3
      pulse(3);
      for (int p = 0; p < 8; p++) begin
         for (int th = 0; th < 8; th++) begin
            cfg_wr(0, 3, p);
            cfg_wr(2, 0, th);
            check("R4 irq vs threshold", int'(mach_irq[0]), (p > th) ? 1 : 0);
            check("R10 id vs threshold", int'(claim_id), (p > th) ? 3 : 0);
         end
      end

      // R6 claim clears, R7 complete releases
      cfg_wr(0, 3, 1);
      cfg_wr(2, 0, 0);
      check("R5 sole winner", int'(claim_id), 3);
      do_claim(0);
      check("R6 claimed drops irq", int'(mach_irq[0]), 0);
      check("R6 claimed drops id", int'(claim_id), 0);
      do_cmpl(3);
      check("R7 complete without level", int'(claim_id), 0);

      // R5 ties and ordering, R9 word packing (source 33 = word 1 bit 1)
      cfg_wr(0, 5, 4);
      cfg_wr(0, 33, 4);
      cfg_wr(0, 7, 2);
      cfg_wr(1, 1, 32'h2);
      @(negedge clk);
      src_level[5] = 1; src_level[33] = 1; src_level[7] = 1;
      @(negedge clk);
      src_level = '0;
      check("R5 tie lowest id", int'(claim_id), 5);
      do_claim(0);
      check("R9 upper word source", int'(claim_id), 33);
      do_claim(0);
      check("R5 lower priority next", int'(claim_id), 7);
      do_claim(0);
      check("R6 all claimed id", int'(claim_id), 0);
      check("R6 all claimed irq", int'(mach_irq[0]), 0);
      do_claim(0);
      check("R6 empty claim no effect", int'(claim_id), 0);

      // R7 complete one source leaves others claimed
      do_cmpl(33);
      check("R7 others stay claimed", int'(claim_id), 0);
      // R2 level held while claimed: re-pends one edge after complete
      src_level[5] = 1;
      @(negedge clk);
      cmpl_id = 6'd5; cmpl_req = 1;
      @(negedge clk);
      cmpl_req = 0;
      check("R2 not yet pending", int'(claim_id), 0);
      @(negedge clk);
      check("R2 pending next edge", int'(claim_id), 5);
      src_level[5] = 0;

      // same edge: claim 5 and complete 7
      @(negedge clk);
      claim_tgt = 0; claim_req = 1; cmpl_id = 6'd7; cmpl_req = 1;
      @(negedge clk);
      claim_req = 0; cmpl_req = 0;
      check("R6 concurrent claim", int'(claim_id), 0);
      pulse(7);
      check("R7 concurrent complete", int'(claim_id), 7);

      // R8 mode routing
      cfg_wr(3, 0, 1);
      check("R8 sup routed", int'(sup_irq[0]), 1);
      check("R8 mach quiet", int'(mach_irq[0]), 0);
      cfg_wr(3, 0, 0);
      check("R8 mach routed", int'(mach_irq[0]), 1);
      check("R8 sup quiet", int'(sup_irq[0]), 0);

      // R3 per-target enables and claimed masking
      check("R3 t1 not enabled", int'(mach_irq[1]), 0);
      cfg_wr(1, 2, 32'h80);
      check("R3 t1 enabled", int'(mach_irq[1]), 1);
      @(negedge clk);
      claim_tgt = 1;
      #1;
      check("R3 t1 winner", int'(claim_id), 7);
      cfg_wr(1, 2, 32'h20);
      check("R3 claimed source masked", int'(mach_irq[1]), 0);
      check("R3 claimed id", int'(claim_id), 0);
      check("R3 t0 unaffected", int'(mach_irq[0]), 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule